// File: doc/BRIEF.md
# Bit-Vector Directory Coherence Controller

This block is the home agent for a handful of memory lines in a distributed shared-memory machine. For every line it holds one presence bit per processor and a dirty flag. Processors send it read requests (shared copy) and write requests (exclusive ownership). The controller answers from its own line storage when no other processor can hold newer data. When another processor owns the line dirty, it forwards the request to that owner, which supplies the requester directly and writes the line back home. The path is requester, directory, owner, requester.

When a write finds other sharers, the controller sends one invalidation per cycle, only to processors whose presence bit is set. It grants ownership only after every acknowledgement has come back. Only one transaction is outstanding at a time. Any request that arrives while one is pending is bounced with a retry message to its sender, so requests to the same line are serialized at the home.

Top module: `coherence_directory`

## Requirements
- R1: After reset no line has any presence bit set, every line is clean, line i holds the value i, and neither msgValid nor retryValid is asserted.
- R2: A read of a clean line produces, one cycle after the request, a message of kind DATA (msgKind=0) to the requester with msgExcl=0 and the stored line value. The requester's presence bit is then set.
- R3: A read of a line held dirty by another processor produces one cycle later a FWD message (msgKind=1) to the owner, with msgReq equal to the requester and msgExcl=0. When the owner's writeback arrives (rspValid=1, rspWb=1), the home stores its data, leaves owner and requester as the only sharers, marks the line clean and sends nothing more.
- R4: A write to a clean line with other sharers sends INV messages (msgKind=2), one per cycle and starting two cycles after the request. They go in ascending processor order to exactly the sharers other than the writer.
- R5: After invalidations, the DATA message with msgExcl=1 and the stored value reaches the writer on the second clock edge after the last outstanding acknowledgement (rspValid=1, rspWb=0), in whatever order the acknowledgements come. No such grant appears while any acknowledgement is outstanding. Afterwards only the writer's bit is set and the line is dirty.
- R6: A write to a clean line that no other processor shares is granted one cycle later with DATA, msgExcl=1 and the stored value. The line then has only the writer's bit set and is dirty.
- R7: A write to a line dirty at another processor sends FWD with msgExcl=1 and msgReq equal to the writer. On writeback the home stores the data, sets only the writer's bit, keeps the line dirty and sends nothing more.
- R8: A request of either kind from the processor that already owns the line dirty is answered one cycle later with DATA, msgExcl=1 and the stored value, and the line's state does not change.
- R9: A request arriving while a transaction is outstanding gets, one cycle later, retryValid with retryDst equal to its source. It produces no other message and changes no line state.
- R10: A dirty line always has exactly one presence bit set, and forwards go to that processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = exclusive (write) request, 0 = shared read |
| reqSrc | input | log2(NUM_PROCS) | Requesting processor |
| reqLine | input | log2(NUM_LINES) | Line addressed |
| rspValid | input | 1 | Response from a processor present |
| rspWb | input | 1 | 1 = writeback with data, 0 = invalidation acknowledgement |
| rspSrc | input | log2(NUM_PROCS) | Responding processor |
| rspData | input | DATA_W | Writeback data |
| msgValid | output | 1 | Outbound message valid (one cycle) |
| msgKind | output | 2 | 0 = DATA, 1 = FWD, 2 = INV |
| msgDst | output | log2(NUM_PROCS) | Destination processor |
| msgReq | output | log2(NUM_PROCS) | Original requester (for FWD and INV) |
| msgLine | output | log2(NUM_LINES) | Line concerned |
| msgExcl | output | 1 | Exclusive grant or exclusive forward |
| msgData | output | DATA_W | Line data for DATA messages |
| retryValid | output | 1 | Retry message valid (one cycle) |
| retryDst | output | log2(NUM_PROCS) | Processor told to retry |

## Verification
The assertions check four things on every cycle. A dirty line keeps exactly one presence bit. An invalidation never targets the writer. No exclusive grant leaves while an acknowledgement is outstanding. A retry only follows a cycle in which a transaction was pending. Only the bench's scenarios can show the rest: the data a reader receives after a forward and writeback, the ascending order of invalidations, the two-edge grant timing under in-order and reverse acknowledgements, and that a retried request leaves no trace in later answers. The bench shows these by replaying long request streams against an arithmetic reference of presence, dirty and line values.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    MSG_DATA = 2'd0,
    MSG_FWD  = 2'd1,
    MSG_INV  = 2'd2
  } msgKind_e;

  // strobes from control to datapath, at most one message-producing strobe set
  typedef struct packed {
    logic accept;
    logic replyShared;
    logic replyOwner;
    logic grantNow;
    logic forward;
    logic startInval;
    logic sendInv;
    logic grantAfterInval;
    logic applyWb;
    logic retry;
  } dirStrobe_t;

endpackage

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_PROCS = 4,
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dirStrobe_t                   strobe,
  input  logic [$clog2(NUM_PROCS)-1:0] inSrc,
  input  logic [$clog2(NUM_LINES)-1:0] inLine,
  input  logic                         inWrite,
  input  logic                         rspValid,
  input  logic                         rspWb,
  input  logic [$clog2(NUM_PROCS)-1:0] rspSrc,
  input  logic [DATA_W-1:0]            rspData,
  output logic                         lineDirty,
  output logic                         ownerIsSrc,
  output logic                         othersAny,
  output logic                         invAny,
  output logic                         ackAny,
  output logic                         wbHit,
  output logic                         msgValid,
  output msgKind_e                     msgKind,
  output logic [$clog2(NUM_PROCS)-1:0] msgDst,
  output logic [$clog2(NUM_PROCS)-1:0] msgReq,
  output logic [$clog2(NUM_LINES)-1:0] msgLine,
  output logic                         msgExcl,
  output logic [DATA_W-1:0]            msgData,
  output logic                         retryValid,
  output logic [$clog2(NUM_PROCS)-1:0] retryDst
);

  localparam int PW = $clog2(NUM_PROCS);
  localparam int LW = $clog2(NUM_LINES);
  localparam logic [NUM_PROCS-1:0] ONE_P = NUM_PROCS'(1);

  logic [NUM_PROCS-1:0] presQ [NUM_LINES];
  logic [DATA_W-1:0]    memQ  [NUM_LINES];
  logic [NUM_LINES-1:0] dirtyQ;
  logic [PW-1:0]        srcQ, ownerQ;
  logic [LW-1:0]        lineQ;
  logic                 writeQ;
  logic [NUM_PROCS-1:0] invPendQ, ackPendQ;

  logic [NUM_PROCS-1:0] inPres, srcBit, capBit;
  logic [PW-1:0]        inOwner, invFirst;

  assign inPres = presQ[inLine];
  assign srcBit = ONE_P << inSrc;
  assign capBit = ONE_P << srcQ;

  always_comb begin
    inOwner  = '0;
    invFirst = '0;
    for (int i = NUM_PROCS - 1; i >= 0; i--) begin
      if (inPres[i])   inOwner  = PW'(i);
      if (invPendQ[i]) invFirst = PW'(i);
    end
  end

  assign lineDirty  = dirtyQ[inLine];
  assign ownerIsSrc = (inOwner == inSrc);
  assign othersAny  = |(inPres & ~srcBit);
  assign invAny     = |invPendQ;
  assign ackAny     = |ackPendQ;
  assign wbHit      = rspValid && rspWb && (rspSrc == ownerQ);

  // next outbound message
  logic          nValid, nExcl;
  msgKind_e      nKind;
  logic [PW-1:0] nDst, nReq;
  logic [LW-1:0] nLine;
  logic [DATA_W-1:0] nData;

  always_comb begin
    nValid = 1'b0;
    nKind  = MSG_DATA;
    nDst   = inSrc;
    nReq   = inSrc;
    nLine  = inLine;
    nExcl  = 1'b0;
    nData  = memQ[inLine];
    if (strobe.replyShared || strobe.replyOwner || strobe.grantNow) begin
      nValid = 1'b1;
      nExcl  = !strobe.replyShared;
    end
    if (strobe.forward) begin
      nValid = 1'b1;
      nKind  = MSG_FWD;
      nDst   = inOwner;
      nExcl  = inWrite;
    end
    if (strobe.sendInv) begin
      nValid = 1'b1;
      nKind  = MSG_INV;
      nDst   = invFirst;
      nReq   = srcQ;
      nLine  = lineQ;
    end
    if (strobe.grantAfterInval) begin
      nValid = 1'b1;
      nExcl  = 1'b1;
      nDst   = srcQ;
      nReq   = srcQ;
      nLine  = lineQ;
      nData  = memQ[lineQ];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        presQ[i] <= '0;
        memQ[i]  <= DATA_W'(i);
      end
      dirtyQ     <= '0;
      srcQ       <= '0;
      ownerQ     <= '0;
      lineQ      <= '0;
      writeQ     <= 1'b0;
      invPendQ   <= '0;
      ackPendQ   <= '0;
      msgValid   <= 1'b0;
      msgKind    <= MSG_DATA;
      msgDst     <= '0;
      msgReq     <= '0;
      msgLine    <= '0;
      msgExcl    <= 1'b0;
      msgData    <= '0;
      retryValid <= 1'b0;
      retryDst   <= '0;
    end else begin
      msgValid   <= nValid;
      msgKind    <= nKind;
      msgDst     <= nDst;
      msgReq     <= nReq;
      msgLine    <= nLine;
      msgExcl    <= nExcl;
      msgData    <= nData;
      retryValid <= strobe.retry;
      retryDst   <= inSrc;
      if (rspValid && !rspWb) ackPendQ[rspSrc] <= 1'b0;
      if (strobe.accept) begin
        srcQ   <= inSrc;
        lineQ  <= inLine;
        writeQ <= inWrite;
        ownerQ <= inOwner;
      end
      if (strobe.replyShared) presQ[inLine] <= inPres | srcBit;
      if (strobe.grantNow) begin
        presQ[inLine]  <= srcBit;
        dirtyQ[inLine] <= 1'b1;
      end
      if (strobe.startInval) begin
        invPendQ <= inPres & ~srcBit;
        ackPendQ <= inPres & ~srcBit;
      end
      if (strobe.sendInv) invPendQ[invFirst] <= 1'b0;
      if (strobe.grantAfterInval) begin
        presQ[lineQ]  <= capBit;
        dirtyQ[lineQ] <= 1'b1;
      end
      if (strobe.applyWb) begin
        memQ[lineQ]   <= rspData;
        presQ[lineQ]  <= writeQ ? capBit : (capBit | (ONE_P << ownerQ));
        dirtyQ[lineQ] <= writeQ;
      end
    end
  end

  // R10
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLineChk
    dirty_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      dirtyQ[g] |-> ($countones(presQ[g]) == 1));
  end

  // R4
  inv_not_writer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgKind == MSG_INV) |-> (msgDst != srcQ));

  // R5
  no_early_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ackPendQ) |=> !(msgValid && msgExcl && msgKind == MSG_DATA));

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       lineDirty,
  input  logic       ownerIsSrc,
  input  logic       othersAny,
  input  logic       invAny,
  input  logic       ackAny,
  input  logic       wbHit,
  output dirStrobe_t strobe,
  output logic       busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_INVAL, ST_WAITWB} state_e;
  state_e stateQ, stateN;

  always_comb begin
    strobe = '0;
    stateN = stateQ;
    unique case (stateQ)
      ST_IDLE: if (reqValid) begin
        if (lineDirty && !ownerIsSrc) begin
          strobe.accept  = 1'b1;
          strobe.forward = 1'b1;
          stateN         = ST_WAITWB;
        end else if (lineDirty) begin
          strobe.replyOwner = 1'b1;
        end else if (!reqWrite) begin
          strobe.replyShared = 1'b1;
        end else if (othersAny) begin
          strobe.accept     = 1'b1;
          strobe.startInval = 1'b1;
          stateN            = ST_INVAL;
        end else begin
          strobe.grantNow = 1'b1;
        end
      end
      ST_INVAL: begin
        strobe.retry = reqValid;
        if (invAny) begin
          strobe.sendInv = 1'b1;
        end else if (!ackAny) begin
          strobe.grantAfterInval = 1'b1;
          stateN                 = ST_IDLE;
        end
      end
      ST_WAITWB: begin
        strobe.retry = reqValid;
        if (wbHit) begin
          strobe.applyWb = 1'b1;
          stateN         = ST_IDLE;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateN;
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/coherence_directory.sv
module coherence_directory
  import dir_pkg::*;
#(
  parameter int NUM_PROCS = 4,
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic                         reqWrite,
  input  logic [$clog2(NUM_PROCS)-1:0] reqSrc,
  input  logic [$clog2(NUM_LINES)-1:0] reqLine,
  input  logic                         rspValid,
  input  logic                         rspWb,
  input  logic [$clog2(NUM_PROCS)-1:0] rspSrc,
  input  logic [DATA_W-1:0]            rspData,
  output logic                         msgValid,
  output logic [1:0]                   msgKind,
  output logic [$clog2(NUM_PROCS)-1:0] msgDst,
  output logic [$clog2(NUM_PROCS)-1:0] msgReq,
  output logic [$clog2(NUM_LINES)-1:0] msgLine,
  output logic                         msgExcl,
  output logic [DATA_W-1:0]            msgData,
  output logic                         retryValid,
  output logic [$clog2(NUM_PROCS)-1:0] retryDst
);

  dirStrobe_t strobe;
  msgKind_e   kindInt;
  logic lineDirty, ownerIsSrc, othersAny, invAny, ackAny, wbHit, busy;

  dir_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .lineDirty(lineDirty), .ownerIsSrc(ownerIsSrc), .othersAny(othersAny),
    .invAny(invAny), .ackAny(ackAny), .wbHit(wbHit),
    .strobe(strobe), .busy(busy)
  );

  dir_datapath #(.NUM_PROCS(NUM_PROCS), .NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inSrc(reqSrc), .inLine(reqLine), .inWrite(reqWrite),
    .rspValid(rspValid), .rspWb(rspWb), .rspSrc(rspSrc), .rspData(rspData),
    .lineDirty(lineDirty), .ownerIsSrc(ownerIsSrc), .othersAny(othersAny),
    .invAny(invAny), .ackAny(ackAny), .wbHit(wbHit),
    .msgValid(msgValid), .msgKind(kindInt), .msgDst(msgDst), .msgReq(msgReq),
    .msgLine(msgLine), .msgExcl(msgExcl), .msgData(msgData),
    .retryValid(retryValid), .retryDst(retryDst)
  );

  assign msgKind = kindInt;

  // R9
  retry_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    retryValid |-> $past(busy));

endmodule

// File: tb/sim_coherence_directory.sv
`timescale 1ns/1ps
module sim_coherence_directory;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqSrc = '0, reqLine = '0;
  logic rspValid = 1'b0, rspWb = 1'b0;
  logic [1:0] rspSrc = '0;
  logic [7:0] rspData = '0;
  logic msgValid, msgExcl, retryValid;
  logic [1:0] msgKind, msgDst, msgReq, msgLine, retryDst;
  logic [7:0] msgData;

  int nChecks = 0, nFail = 0;
  logic [3:0] refPres [4];
  logic       refDirty [4];
  logic [7:0] refMem [4];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  coherence_directory #(.NUM_PROCS(4), .NUM_LINES(4), .DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSrc(reqSrc), .reqLine(reqLine), .rspValid(rspValid), .rspWb(rspWb),
    .rspSrc(rspSrc), .rspData(rspData), .msgValid(msgValid), .msgKind(msgKind),
    .msgDst(msgDst), .msgReq(msgReq), .msgLine(msgLine), .msgExcl(msgExcl),
    .msgData(msgData), .retryValid(retryValid), .retryDst(retryDst)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic chkData(input string req, input int dst, input int line, input int excl);
    chk(req, "msgValid", int'(msgValid), 1);
    chk(req, "msgKind", int'(msgKind), 0);
    chk(req, "msgDst", int'(msgDst), dst);
    chk(req, "msgLine", int'(msgLine), line);
    chk(req, "msgExcl", int'(msgExcl), excl);
    chk(req, "msgData", int'(msgData), int'(refMem[line]));
  endtask

  // one full transaction; ackRev: acks held back and returned in reverse order
  task automatic doTxn(input int src, input int line, input int write,
                       input bit ackRev, input bit injRetry);
    int own;
    logic [3:0] srcBit, others;
    logic [7:0] wb;
    own = 0;
    for (int i = 3; i >= 0; i--) if (refPres[line][i]) own = i;
    srcBit = 4'(1 << src);
    @(negedge clk);
    reqValid = 1'b1; reqSrc = 2'(src); reqLine = 2'(line); reqWrite = write[0];
    @(negedge clk);
    reqValid = 1'b0;
    if (refDirty[line] && own != src) begin
      // R3 / R7 / R10: forward to the single owner
      chk(write ? "R7" : "R3", "msgValid", int'(msgValid), 1);
      chk(write ? "R7" : "R3", "msgKind", int'(msgKind), 1);
      chk("R10", "fwd msgDst", int'(msgDst), own);
      chk(write ? "R7" : "R3", "msgReq", int'(msgReq), src);
      chk(write ? "R7" : "R3", "msgExcl", int'(msgExcl), write);
      if (injRetry) begin
        reqValid = 1'b1; reqSrc = 2'((src + 1) % 4); reqLine = 2'(line ^ 1);
        reqWrite = lfsr[0];
        @(negedge clk);
        reqValid = 1'b0;
        chk("R9", "retryValid", int'(retryValid), 1);
        chk("R9", "retryDst", int'(retryDst), (src + 1) % 4);
        chk("R9", "no msg with retry", int'(msgValid), 0);
      end
      wb = lfsr[15:8] ^ 8'h5A;
      rspValid = 1'b1; rspWb = 1'b1; rspSrc = 2'(own); rspData = wb;
      @(negedge clk);
      rspValid = 1'b0;
      chk(write ? "R7" : "R3", "no msg after wb", int'(msgValid), 0);
      chk("R9", "no stray retry", int'(retryValid), 0);
      refMem[line] = wb;
      if (write) refPres[line] = srcBit;
      else begin refPres[line] = srcBit | 4'(1 << own); refDirty[line] = 1'b0; end
    end else if (refDirty[line]) begin
      chkData("R8", src, line, 1);
    end else if (!write) begin
      chkData("R2", src, line, 0);
      refPres[line] = refPres[line] | srcBit;
    end else begin
      others = refPres[line] & ~srcBit;
      if (others == 4'b0) begin
        chkData("R6", src, line, 1);
      end else begin
        for (int p = 0; p < 4; p++) begin
          if (others[p]) begin
            @(negedge clk);
            rspValid = 1'b0;
            chk("R4", "INV msgValid", int'(msgValid), 1);
            chk("R4", "INV msgKind", int'(msgKind), 2);
            chk("R4", "INV msgDst", int'(msgDst), p);
            chk("R4", "INV msgLine", int'(msgLine), line);
            if (!ackRev) begin rspValid = 1'b1; rspWb = 1'b0; rspSrc = 2'(p); end
          end
        end
        if (ackRev) begin
          for (int p = 3; p >= 0; p--) begin
            if (others[p]) begin
              rspValid = 1'b1; rspWb = 1'b0; rspSrc = 2'(p);
              @(negedge clk);
              rspValid = 1'b0;
              chk("R5", "no grant before acks", int'(msgValid), 0);
            end
          end
        end else begin
          @(negedge clk);
          rspValid = 1'b0;
          chk("R5", "no grant one edge after ack", int'(msgValid), 0);
        end
        @(negedge clk);
        chkData("R5", src, line, 1);
      end
      refPres[line] = srcBit;
      refDirty[line] = 1'b1;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      refPres[i] = '0; refDirty[i] = 1'b0; refMem[i] = 8'(i);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "msgValid after reset", int'(msgValid), 0);
    chk("R1", "retryValid after reset", int'(retryValid), 0);
    // R1 / R2: initial line contents via clean reads
    for (int l = 0; l < 4; l++) doTxn(0, l, 0, 1'b0, 1'b0);
    // R4 / R5: three sharers, acks in order
    doTxn(1, 0, 0, 1'b0, 1'b0);
    doTxn(2, 0, 0, 1'b0, 1'b0);
    doTxn(3, 0, 1, 1'b0, 1'b0);
    // R3 / R9: read of dirty line with a retried request in between
    doTxn(2, 0, 0, 1'b0, 1'b1);
    // R5: acks in reverse order
    doTxn(1, 0, 1, 1'b1, 1'b0);
    // R8: owner asks again
    doTxn(1, 0, 0, 1'b0, 1'b0);
    doTxn(1, 0, 1, 1'b0, 1'b0);
    // R7: write to line dirty elsewhere
    doTxn(0, 0, 1, 1'b0, 1'b1);
    // R4 single sharer, R6 sole sharer
    doTxn(2, 1, 1, 1'b0, 1'b0);
    doTxn(0, 2, 1, 1'b0, 1'b0);
    // sweep of pseudo-random request streams
    for (int n = 0; n < 600; n++) begin
      stepLfsr();
      doTxn(int'(lfsr[1:0]), int'(lfsr[3:2]), int'(lfsr[4] & lfsr[6]),
            lfsr[7], lfsr[9]);
    end
    summary();
    $finish;
  end

endmodule